// File: doc/BRIEF.md
# ECC Memory Control/Status Register with Error Logging

This block is the 16-bit control and status register that sits beside an error-correcting memory controller. Software reads and writes it through a simple register port. The memory read path reports each completed read to it as an event: a valid strobe, single-error and double-error indications, the upper address bits of the access, and the raw check bits taken from the array. The register keeps the flags and the enable and mode controls. It also keeps the captured error location, or the check bits when diagnostic capture is on.

Several decisions are returned to the read path in the same cycle as the event. The block tells the read path whether correction and diagnostic capture apply to the current address, since one 16K-word region can be protected from both. It also drives the bus parity-error line for uncorrectable reads. A 7-bit window in the register shows one of four things, chosen by the mode and flag bits: the written value, the low part of the logged address, the high part of the logged address, or the captured check bits.

Top module: `eccmem_csr`

## Requirements
- R1: Reset, and `init_clr` one cycle later, leave bits 0–4 and 13–15 at zero. An `init_clr` leaves the value written into bits 11–5 intact. When `init_clr` and a register write arrive in the same cycle, `init_clr` wins.
- R2: Bit 12 always reads 0. When `wide_bus` is 0, bit 14 reads 0 and cannot be set, and address bits A21–A18 are treated as zero, both for logging and for the region decode.
- R3: `par_err` is high in a cycle with `rd_valid` exactly when bit 0 is 1 and the read is uncorrectable. It is low in every other cycle.
- R4: Every single-bit error sets bit 4 on the next cycle, whatever the correction-disable bit says.
- R5: Bit 15 is set by a double error. It is also set by a single error when correction is disabled for that access (bit 1 = 1 and the access is outside the protected region).
- R6: An error read captures A21–A11. With bit 14 = 0, bits 11–5 show A17–A11. With bit 14 = 1, bits 8–5 show A21–A18 and bits 11–9 read 0.
- R7: When correction is enabled and bit 15 is already 1, a single error does not replace the logged address. An uncorrectable error always replaces it.
- R8: With bit 2 = 1, every read outside the protected region loads its check bits into bits 11–5, and bit 14 has no effect on what is shown. Once bit 2 is cleared, the logged address is visible again.
- R9: A register write discards any captured check bits, so bits 11–5 show the written value while bit 2 stays 1. The write does not disturb the logged address.
- R10: Bit 13 turns protection on. Bit 3 picks the protected region by address index A21–A15: index 0 when bit 3 = 0, index 1 when bit 3 = 1. An access inside the region raises `prot_hit` and behaves as if bits 1 and 2 were 0.
- R11: Outside diagnostic mode, bits 11–5 show the written value only while bits 15, 14 and 4 are all 0.
- R12: A register write loads bits 0–4, 13–15 and the 11–5 field from `wr_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wide_bus | input | 1 | 1 = 22-bit address bus, 0 = 18-bit bus |
| init_clr | input | 1 | Bus init: clears the control and flag bits |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| rd_valid | input | 1 | A memory read completed this cycle |
| err_addr | input | 11 | Address bits A21–A11 of the read |
| err_single | input | 1 | Single-bit error detected on the read |
| err_double | input | 1 | Double-bit error detected on the read (takes precedence) |
| chk_bits | input | 7 | Check bits retrieved from the array for the read |
| par_err | output | 1 | Bus parity-error indication for an uncorrectable read |
| prot_hit | output | 1 | The read address lies in the protected region |
| eff_corr_off | output | 1 | Correction is disabled for this access |
| eff_diag | output | 1 | Diagnostic check-bit capture applies to this access |

## Verification
The hardest state to reach is the one where two pieces of stored information compete for the 7-bit window. A logged address has to be kept while check bits are being captured over it. The stimulus then has to show that the address survives a write that discards the check bits, and that it reappears when diagnostic mode is left. The scoreboard gets there with a fixed order of steps: log an error address, enter diagnostic mode and capture check bits, write with the high-half select set, and then leave the mode. At each step the expected window contents are worked out from the requirements. The protected region is exercised in both region selections and again under the narrow bus, where address bits that would miss the region in wide mode are masked down into it.

// File: rtl/eccmem_csr_pkg.sv
package eccmem_csr_pkg;

  localparam int CSR_W   = 16;
  localparam int FIELD_W = 7;

  // Bit positions in the register image
  localparam int B_PBE      = 0;
  localparam int B_CORR_OFF = 1;
  localparam int B_DIAG     = 2;
  localparam int B_REGION   = 3;
  localparam int B_SBE      = 4;
  localparam int B_FIELD_LO = 5;
  localparam int B_FIELD_HI = B_FIELD_LO + FIELD_W - 1;
  localparam int B_ZERO     = 12;
  localparam int B_PROT     = 13;
  localparam int B_HISEL    = 14;
  localparam int B_UE       = 15;

  // Bits that are cleared by init
  typedef struct packed {
    logic ue;
    logic hi_sel;
    logic prot_en;
    logic sbe;
    logic region;
    logic diag;
    logic corr_off;
    logic pbe_en;
  } ctrl_t;

  typedef enum logic [1:0] {
    VIEW_WR     = 2'd0,
    VIEW_LOG_LO = 2'd1,
    VIEW_LOG_HI = 2'd2,
    VIEW_DIAG   = 2'd3
  } view_e;

endpackage

// File: rtl/eccmem_csr_decode.sv
module eccmem_csr_decode
  import eccmem_csr_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int NARROW_W   = 18,
  parameter int REGION_LSB = 15
) (
  input  logic                                  wide_bus,
  input  logic [ADDR_W-NARROW_W+FIELD_W-1:0]    err_addr,
  input  logic                                  prot_en,
  input  logic                                  region_sel,
  input  logic                                  corr_off,
  input  logic                                  diag_on,
  input  logic                                  err_single,
  input  logic                                  err_double,
  output logic [ADDR_W-NARROW_W+FIELD_W-1:0]    addr_eff,
  output logic                                  prot_hit,
  output logic                                  eff_corr_off,
  output logic                                  eff_diag,
  output logic                                  uncorr,
  output logic                                  sgl_only
);

  localparam int LOG_LSB = NARROW_W - FIELD_W;
  localparam int LOG_W   = ADDR_W - LOG_LSB;
  localparam int HI_W    = ADDR_W - NARROW_W;
  localparam int IDX_LO  = REGION_LSB - LOG_LSB;
  localparam int IDX_W   = LOG_W - IDX_LO;

  logic [IDX_W-1:0] region_idx;

  // Upper address bits are only meaningful on the wide bus
  generate
    if (HI_W > 0) begin : g_mask
      always_comb begin
        addr_eff = err_addr;
        if (!wide_bus) addr_eff[LOG_W-1 -: HI_W] = '0;
      end
    end else begin : g_pass
      logic unused_wide;
      assign unused_wide = wide_bus;
      assign addr_eff    = err_addr;
    end
  endgenerate

  assign region_idx   = addr_eff[LOG_W-1:IDX_LO];
  assign prot_hit     = prot_en && (region_idx == IDX_W'(region_sel));
  assign eff_corr_off = corr_off && !prot_hit;
  assign eff_diag     = diag_on && !prot_hit;
  assign sgl_only     = err_single && !err_double;
  assign uncorr       = err_double || (sgl_only && eff_corr_off);

endmodule

// File: rtl/eccmem_csr_log.sv
module eccmem_csr_log
  import eccmem_csr_pkg::*;
#(
  parameter int LOG_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [FIELD_W-1:0] wr_field,
  input  logic               log_en,
  input  logic [LOG_W-1:0]   log_addr,
  input  logic               diag_ld,
  input  logic [FIELD_W-1:0] chk_bits,
  output logic [FIELD_W-1:0] wr_field_q,
  output logic [LOG_W-1:0]   log_q,
  output logic [FIELD_W-1:0] diag_q,
  output logic               diag_vld_q
);

  logic [FIELD_W-1:0] wr_field_d;
  logic [LOG_W-1:0]   log_d;
  logic [FIELD_W-1:0] diag_d;
  logic               diag_vld_d;
  logic               diag_we;

  always_comb begin
    wr_field_d = wr_en  ? wr_field : wr_field_q;
    log_d      = log_en ? log_addr : log_q;
    diag_d     = diag_ld ? chk_bits : diag_q;
    diag_vld_d = diag_vld_q;
    if (wr_en)   diag_vld_d = 1'b0;
    if (diag_ld) diag_vld_d = 1'b1;
  end

  assign diag_we = wr_en || diag_ld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_field_q <= '0;
      log_q      <= '0;
      diag_q     <= '0;
      diag_vld_q <= 1'b0;
    end else begin
      if (wr_en)   wr_field_q <= wr_field_d;
      if (log_en)  log_q      <= log_d;
      if (diag_ld) diag_q     <= diag_d;
      if (diag_we) diag_vld_q <= diag_vld_d;
    end
  end

endmodule

// File: rtl/eccmem_csr_view.sv
module eccmem_csr_view
  import eccmem_csr_pkg::*;
#(
  parameter int LOG_W = 11,
  parameter int HI_W  = 4
) (
  input  ctrl_t              ctrl,
  input  logic               wide_bus,
  input  logic [FIELD_W-1:0] wr_field_q,
  input  logic [LOG_W-1:0]   log_q,
  input  logic [FIELD_W-1:0] diag_q,
  input  logic               diag_vld_q,
  output logic [CSR_W-1:0]   rd_data
);

  localparam int LO_W = LOG_W - HI_W;

  view_e              sel;
  logic               hi_eff;
  logic [FIELD_W-1:0] field;

  assign hi_eff = ctrl.hi_sel && wide_bus;

  always_comb begin
    if (ctrl.diag)
      sel = diag_vld_q ? VIEW_DIAG : VIEW_WR;
    else if (ctrl.ue || hi_eff || ctrl.sbe)
      sel = hi_eff ? VIEW_LOG_HI : VIEW_LOG_LO;
    else
      sel = VIEW_WR;
  end

  always_comb begin
    unique case (sel)
      VIEW_LOG_LO: field = FIELD_W'(log_q[LO_W-1:0]);
      VIEW_LOG_HI: field = FIELD_W'(log_q[LOG_W-1 -: HI_W]);
      VIEW_DIAG:   field = diag_q;
      default:     field = wr_field_q;
    endcase
  end

  always_comb begin
    rd_data                        = '0;
    rd_data[B_PBE]                 = ctrl.pbe_en;
    rd_data[B_CORR_OFF]            = ctrl.corr_off;
    rd_data[B_DIAG]                = ctrl.diag;
    rd_data[B_REGION]              = ctrl.region;
    rd_data[B_SBE]                 = ctrl.sbe;
    rd_data[B_FIELD_HI:B_FIELD_LO] = field;
    rd_data[B_PROT]                = ctrl.prot_en;
    rd_data[B_HISEL]               = hi_eff;
    rd_data[B_UE]                  = ctrl.ue;
  end

endmodule

// File: rtl/eccmem_csr.sv
module eccmem_csr
  import eccmem_csr_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int NARROW_W   = 18,
  parameter int REGION_LSB = 15
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wide_bus,
  input  logic                                init_clr,
  input  logic                                wr_en,
  input  logic [CSR_W-1:0]                    wr_data,
  output logic [CSR_W-1:0]                    rd_data,
  input  logic                                rd_valid,
  input  logic [ADDR_W-NARROW_W+FIELD_W-1:0]  err_addr,
  input  logic                                err_single,
  input  logic                                err_double,
  input  logic [FIELD_W-1:0]                  chk_bits,
  output logic                                par_err,
  output logic                                prot_hit,
  output logic                                eff_corr_off,
  output logic                                eff_diag
);

  localparam int LOG_LSB = NARROW_W - FIELD_W;
  localparam int LOG_W   = ADDR_W - LOG_LSB;
  localparam int HI_W    = ADDR_W - NARROW_W;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_we;
  logic [LOG_W-1:0] addr_eff;
  logic             uncorr, sgl_only;
  logic             log_en, diag_ld;
  logic [FIELD_W-1:0] wr_field_q, diag_q;
  logic [LOG_W-1:0]   log_q;
  logic               diag_vld_q;
  logic               unused_zero_bit;

  assign unused_zero_bit = wr_data[B_ZERO];

  eccmem_csr_decode #(
    .ADDR_W(ADDR_W), .NARROW_W(NARROW_W), .REGION_LSB(REGION_LSB)
  ) u_decode (
    .wide_bus    (wide_bus),
    .err_addr    (err_addr),
    .prot_en     (ctrl_q.prot_en),
    .region_sel  (ctrl_q.region),
    .corr_off    (ctrl_q.corr_off),
    .diag_on     (ctrl_q.diag),
    .err_single  (err_single),
    .err_double  (err_double),
    .addr_eff    (addr_eff),
    .prot_hit    (prot_hit),
    .eff_corr_off(eff_corr_off),
    .eff_diag    (eff_diag),
    .uncorr      (uncorr),
    .sgl_only    (sgl_only)
  );

  // Control and flag next state: write, then events, then init on top
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en) begin
      ctrl_d.pbe_en   = wr_data[B_PBE];
      ctrl_d.corr_off = wr_data[B_CORR_OFF];
      ctrl_d.diag     = wr_data[B_DIAG];
      ctrl_d.region   = wr_data[B_REGION];
      ctrl_d.sbe      = wr_data[B_SBE];
      ctrl_d.prot_en  = wr_data[B_PROT];
      ctrl_d.hi_sel   = wr_data[B_HISEL] && wide_bus;
      ctrl_d.ue       = wr_data[B_UE];
    end
    if (rd_valid) begin
      if (sgl_only) ctrl_d.sbe = 1'b1;
      if (uncorr)   ctrl_d.ue  = 1'b1;
    end
    if (init_clr) ctrl_d = '0;
  end

  assign ctrl_we = wr_en || rd_valid || init_clr;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  // A latched uncorrectable error shields the log from correctable ones
  assign log_en  = rd_valid && (uncorr || (sgl_only && !ctrl_q.ue));
  assign diag_ld = rd_valid && eff_diag;
  assign par_err = rd_valid && ctrl_q.pbe_en && uncorr;

  eccmem_csr_log #(.LOG_W(LOG_W)) u_log (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .wr_field  (wr_data[B_FIELD_HI:B_FIELD_LO]),
    .log_en    (log_en),
    .log_addr  (addr_eff),
    .diag_ld   (diag_ld),
    .chk_bits  (chk_bits),
    .wr_field_q(wr_field_q),
    .log_q     (log_q),
    .diag_q    (diag_q),
    .diag_vld_q(diag_vld_q)
  );

  eccmem_csr_view #(.LOG_W(LOG_W), .HI_W(HI_W)) u_view (
    .ctrl      (ctrl_q),
    .wide_bus  (wide_bus),
    .wr_field_q(wr_field_q),
    .log_q     (log_q),
    .diag_q    (diag_q),
    .diag_vld_q(diag_vld_q),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/eccmem_csr_chk.sv
module eccmem_csr_chk
  import eccmem_csr_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wide_bus,
  input logic               init_clr,
  input logic               wr_en,
  input logic [CSR_W-1:0]   rd_data,
  input logic               rd_valid,
  input logic               err_single,
  input logic               err_double,
  input logic [FIELD_W-1:0] chk_bits,
  input logic               par_err,
  input logic               prot_hit,
  input logic               eff_corr_off,
  input logic               eff_diag
);

  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr |=> (rd_data & 16'hE01F) == 16'h0000);

  p_zero_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_ZERO]);

  p_narrow_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_bus |-> !rd_data[B_HISEL]);

  p_par_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> (rd_valid && rd_data[B_PBE]));

  p_par_double_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err_double && rd_data[B_PBE]) |-> par_err);

  p_sbe_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err_single && !err_double && !init_clr) |=> rd_data[B_SBE]);

  p_ue_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && err_double && !init_clr) |=> rd_data[B_UE]);

  p_diag_show_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && eff_diag && !init_clr && !wr_en)
      |=> rd_data[B_FIELD_HI:B_FIELD_LO] == $past(chk_bits));

  p_prot_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    prot_hit |-> (!eff_corr_off && !eff_diag));

endmodule

bind eccmem_csr eccmem_csr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .wide_bus    (wide_bus),
  .init_clr    (init_clr),
  .wr_en       (wr_en),
  .rd_data     (rd_data),
  .rd_valid    (rd_valid),
  .err_single  (err_single),
  .err_double  (err_double),
  .chk_bits    (chk_bits),
  .par_err     (par_err),
  .prot_hit    (prot_hit),
  .eff_corr_off(eff_corr_off),
  .eff_diag    (eff_diag)
);

// File: tb/eccmem_csr_bench.sv
module eccmem_csr_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wide_bus;
  logic        init_clr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [10:0] err_addr;
  logic        err_single;
  logic        err_double;
  logic [6:0]  chk_bits;
  logic        par_err, prot_hit, eff_corr_off, eff_diag;

  eccmem_csr u_eccmem_csr (
    .clk(clk), .rst_n(rst_n), .wide_bus(wide_bus), .init_clr(init_clr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .rd_valid(rd_valid),
    .err_addr(err_addr), .err_single(err_single), .err_double(err_double),
    .chk_bits(chk_bits), .par_err(par_err), .prot_hit(prot_hit),
    .eff_corr_off(eff_corr_off), .eff_diag(eff_diag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    int          sig;   // 0: rd_data, 1: {prot_hit, par_err, eff_diag, eff_corr_off}
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_checks = 0;
  int    n_fails = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares due items at a point well clear of both edges
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD*3/10);
      for (int i = 0; i < sbq.size(); ) begin
        if (sbq[i].due == cyc) begin
          logic [15:0] act;
          act = (sbq[i].sig == 0) ? rd_data
                                  : {12'h000, prot_hit, par_err, eff_diag, eff_corr_off};
          n_checks++;
          if (act !== sbq[i].exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", sbq[i].req, act, sbq[i].exp);
          end
          sbq.delete(i);
        end else begin
          i++;
        end
      end
    end
  end

  task automatic idle_in();
    init_clr = 1'b0; wr_en = 1'b0; wr_data = '0; rd_valid = 1'b0;
    err_addr = '0; err_single = 1'b0; err_double = 1'b0; chk_bits = '0;
  endtask

  task automatic exp_reg(input logic [15:0] v, input string req);
    item_t it; it.due = cyc + 1; it.sig = 0; it.exp = v; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic exp_comb(input logic [3:0] v, input string req);
    item_t it; it.due = cyc; it.sig = 1; it.exp = {12'h000, v}; it.req = req;
    sbq.push_back(it);
  endtask

  task automatic op_idle();
    @(negedge clk); idle_in();
  endtask

  task automatic op_write(input logic [15:0] v);
    @(negedge clk); idle_in(); wr_en = 1'b1; wr_data = v;
  endtask

  task automatic op_init();
    @(negedge clk); idle_in(); init_clr = 1'b1;
  endtask

  task automatic op_read(input logic [21:0] a, input logic s, input logic d,
                         input logic [6:0] c);
    @(negedge clk); idle_in();
    rd_valid = 1'b1; err_addr = a[21:11]; err_single = s; err_double = d; chk_bits = c;
  endtask

  localparam logic [21:0] ADDR_A  = {4'hA, 7'h35, 11'h123};
  localparam logic [21:0] ADDR_B  = {4'h3, 7'h12, 11'h7FE};
  localparam logic [21:0] ADDR_P0 = 22'h001234;
  localparam logic [21:0] ADDR_Q1 = 22'h00A000;
  localparam logic [21:0] ADDR_R1 = 22'h009000;
  localparam logic [21:0] ADDR_N  = {4'hF, 18'h09000};

  initial begin
    idle_in();
    wide_bus = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    op_idle();            exp_reg(16'h0000, "R1 reset state");
    op_write(16'hFFFF);   exp_reg(16'hEFFF, "R12 write all, R2 bit12 zero");
    op_init();            exp_reg(16'h0FE0, "R1 init keeps field");
    op_read(ADDR_A, 1, 0, 7'h00);
    exp_comb(4'b0000, "R3 no par_err when disabled");
    exp_reg(16'h06B0, "R4 R6 single logged low half");
    op_write(16'h4000);   exp_reg(16'h4140, "R6 high half, R9 write keeps addr");
    op_write(16'h0AA1);   exp_reg(16'h0AA1, "R11 written field visible");
    op_read(ADDR_B, 0, 1, 7'h00);
    exp_comb(4'b0100, "R3 par_err on double");
    exp_reg(16'h8241, "R5 R7 double overwrites log");
    op_read(ADDR_A, 1, 0, 7'h00);
    exp_comb(4'b0000, "R3 correctable no par_err");
    exp_reg(16'h8251, "R7 single blocked while ue set");
    op_write(16'hC001);   exp_reg(16'hC061, "R6 high half of double addr");
    op_write(16'h0003);   exp_reg(16'h0003, "R11 flags clear shows written");
    op_read(ADDR_A, 1, 0, 7'h00);
    exp_comb(4'b0101, "R3 R5 single uncorrectable when correction off");
    exp_reg(16'h86B3, "R5 single sets ue with correction off");
    op_write(16'h0004);   exp_reg(16'h0004, "R9 diag entry shows written");
    op_read(ADDR_A, 0, 0, 7'h5A);
    exp_comb(4'b0010, "R8 diag effective");
    exp_reg(16'h0B44, "R8 check bits captured");
    op_write(16'h4004);   exp_reg(16'h4004, "R9 write discards check bits");
    op_read(ADDR_A, 0, 0, 7'h21);
    exp_reg(16'h4424, "R8 hi select no effect in diag");
    op_write(16'h4000);   exp_reg(16'h4140, "R8 address back after diag off");
    op_write(16'h2006);   exp_reg(16'h2006, "R12 prot setup");
    op_read(ADDR_P0, 1, 0, 7'h33);
    exp_comb(4'b1000, "R10 region0 hit ignores modes");
    exp_reg(16'h2016, "R10 no diag load in region");
    op_read(ADDR_Q1, 0, 0, 7'h7F);
    exp_comb(4'b0011, "R10 outside region modes apply");
    exp_reg(16'h2FF6, "R10 diag load outside region");
    op_write(16'h0010);   exp_reg(16'h0050, "R10 protected single logged as correctable");
    op_write(16'h200E);   exp_reg(16'h200E, "R12 region1 setup");
    op_read(ADDR_R1, 0, 0, 7'h00);
    exp_comb(4'b1000, "R10 region1 hit");
    exp_reg(16'h200E, "R10 region1 no load");
    op_read(ADDR_P0, 0, 0, 7'h11);
    exp_comb(4'b0011, "R10 region0 miss when region1");
    exp_reg(16'h222E, "R10 load outside region1");
    @(negedge clk); idle_in(); wide_bus = 1'b0;
    op_write(16'hFFFF);   exp_reg(16'hAFFF, "R2 narrow bit14 zero");
    op_read(ADDR_N, 0, 0, 7'h00);
    exp_comb(4'b1000, "R2 narrow masks upper addr into region1");
    op_init();            exp_reg(16'h0FE0, "R1 init again");
    op_idle();
    op_idle();
    op_idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule